// File: doc/BRIEF.md
# Programmable-Device Reconfiguration Start Sequencer

This controller opens a reconfiguration cycle on an external programmable device. The device has two handshake lines. One is an active-low program request that the controller drives. The other is an active-low initialisation status line that the device drives. On a start pulse the controller pulls the program request low and keeps it low for at least a minimum number of cycles. It then waits until it has seen the status line go low. Only after that does it release the request and wait for the status line to come back high, which means the device will accept configuration data.

The controller never assumes a response has arrived after a fixed delay. Every phase advance is triggered by an observed change on the status line. Each of the two waits has its own cycle-count watchdog, so a device that does not answer gives an error code instead of a hang. The status input passes through a two-flop synchronizer before any decision uses it.

All pins are plain control and status levels or pulses. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `cfg_reset_seq`

## Requirements
- R1: After reset the program request is high (released), and busy, ready, the error flag and the error code (2'b00) are all low.
- R2: A start pulse is accepted only when the sequencer is idle, ready or in error. A start pulse while busy has no effect on the sequence or its timing.
- R3: Once a start is accepted, the program request goes low on the next clock edge. It is held low for at least MIN_PULSE cycles, and it is released only after the status line has been observed low.
- R4: The status input reaches the decision logic through two flip-flops. A low that the device drives d cycles after the request falls can release the request no earlier than edge d+3 after the start edge, so the release edge is max(MIN_PULSE+1, d+3).
- R5: If the status line has not been observed low by LOW_TIMEOUT cycles after the request fell, the request is released, the error flag sets and the error code is 2'b01. LOW_TIMEOUT must exceed MIN_PULSE.
- R6: After release, the first observed high on the status line moves the sequencer to ready. The ready output pulses high for exactly one cycle, at edge r+h+3, where r is the release edge and h is the device's high delay.
- R7: If the status line is not observed high within HIGH_TIMEOUT cycles of entering the high wait, the error flag sets with code 2'b10 at edge r+1+HIGH_TIMEOUT. By default HIGH_TIMEOUT is CLK_HZ/200 cycles (5 ms).
- R8: Busy is high from the cycle after an accepted start until the sequencer reaches ready or error, and it is high whenever the program request is low.
- R9: The error flag and code hold their value until the next accepted start, which clears them on the same edge that pulls the program request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a reconfiguration cycle |
| init_n_i | input | 1 | Device initialisation status, active low, asynchronous |
| prog_n_o | output | 1 | Program request to the device, active low |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | One-cycle pulse: device ready for configuration data |
| err_o | output | 1 | Sticky timeout flag |
| err_code_o | output | 2 | 01 no low response, 10 no high response, 00 none |

## Verification
Internal faults show up at the ports as shifts in timing. A wrong phase counter changes how long the request stays low, and that shows on prog_n_o at the release edge. A broken synchronizer or status latch moves the ready or error edge by one or more cycles relative to the device's response delay. Sweeping both response delays across the timeout boundaries gives each wrong state a predicted edge at which it must differ: the release edge, the ready edge or the error edge of that run. A run therefore exposes the fault within a few tens of cycles.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PULL,
    SQ_HOLD_LO,
    SQ_LET_GO,
    SQ_HOLD_HI,
    SQ_DONE,
    SQ_FAULT
  } seq_state_t;

  localparam logic [1:0] CODE_NONE    = 2'b00;
  localparam logic [1:0] CODE_NO_LOW  = 2'b01;
  localparam logic [1:0] CODE_NO_HIGH = 2'b10;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  // watchdog count never wraps between clears (R5, R7 rely on it)
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int MIN_PULSE    = 100,
  parameter int LOW_TIMEOUT  = CLK_HZ / 100,
  parameter int HIGH_TIMEOUT = CLK_HZ / 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       init_n_i,
  output logic       prog_n_o,
  output logic       busy_o,
  output logic       ready_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);

  localparam int MAX_LIM_A = (LOW_TIMEOUT > HIGH_TIMEOUT) ? LOW_TIMEOUT : HIGH_TIMEOUT;
  localparam int MAX_LIM   = (MAX_LIM_A > MIN_PULSE) ? MAX_LIM_A : MIN_PULSE;
  localparam int CNT_W     = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_PULSE - 1);
  localparam logic [CNT_W-1:0] LO_LAST  = CNT_W'(LOW_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(HIGH_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] MIN_VAL  = CNT_W'(MIN_PULSE);

  seq_state_t       state_q, state_d;
  logic             stat_s;       // synchronized status, active low
  logic [CNT_W-1:0] cnt_q;
  logic             tmr_clr;
  logic             start_ok;
  logic             low_seen_q;
  logic             seen_low;
  logic             ready_q;
  logic             err_q;
  logic [1:0]       code_q;

  cfg_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (init_n_i),
    .q_o   (stat_s)
  );

  cfg_cycle_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .count_o (cnt_q)
  );

  assign start_ok = start_i &&
                    (state_q == SQ_IDLE || state_q == SQ_DONE || state_q == SQ_FAULT);
  assign seen_low = low_seen_q || !stat_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE, SQ_DONE, SQ_FAULT:
        if (start_ok) state_d = SQ_PULL;
      SQ_PULL:
        if (cnt_q == MIN_LAST) state_d = SQ_HOLD_LO;
      SQ_HOLD_LO:
        if (seen_low)              state_d = SQ_LET_GO;
        else if (cnt_q == LO_LAST) state_d = SQ_FAULT;
      SQ_LET_GO:
        state_d = SQ_HOLD_HI;
      SQ_HOLD_HI:
        if (stat_s)                state_d = SQ_DONE;
        else if (cnt_q == HI_LAST) state_d = SQ_FAULT;
      default:
        state_d = SQ_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q) &&
                   (state_d == SQ_PULL || state_d == SQ_HOLD_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      low_seen_q <= 1'b0;
      ready_q    <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= CODE_NONE;
    end else begin
      state_q <= state_d;
      if (start_ok)
        low_seen_q <= 1'b0;
      else if ((state_q == SQ_PULL || state_q == SQ_HOLD_LO) && !stat_s)
        low_seen_q <= 1'b1;
      ready_q <= (state_q == SQ_HOLD_HI) && (state_d == SQ_DONE);
      if (start_ok) begin
        err_q  <= 1'b0;
        code_q <= CODE_NONE;
      end else if (state_d == SQ_FAULT && state_q != SQ_FAULT) begin
        err_q  <= 1'b1;
        code_q <= (state_q == SQ_HOLD_LO) ? CODE_NO_LOW : CODE_NO_HIGH;
      end
    end
  end

  assign prog_n_o   = !(state_q == SQ_PULL || state_q == SQ_HOLD_LO);
  assign busy_o     = (state_q == SQ_PULL) || (state_q == SQ_HOLD_LO) ||
                      (state_q == SQ_LET_GO) || (state_q == SQ_HOLD_HI);
  assign ready_o    = ready_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

  // R3: request released only after the minimum low time
  p_prog_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> $past(cnt_q) >= MIN_VAL);

  // R6: ready is a single-cycle pulse
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R5/R7: a raised error always carries a nonzero code
  p_err_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o == CODE_NO_LOW || err_code_o == CODE_NO_HIGH));

  // R9: a cleared flag carries no code
  p_code_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> err_code_o == CODE_NONE);

  // R9: error is sticky until a start arrives
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R8: low request implies busy
  p_busy_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o);

  // R6/R8: ready never coincides with busy
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !busy_o);

endmodule

// File: tb/cfg_reset_seq_bench.sv
module cfg_reset_seq_bench;

  localparam int MINP = 4;
  localparam int LOT  = 12;
  localparam int HIT  = 10;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic init_n_i = 1'b1;
  logic prog_n_o, busy_o, ready_o, err_o;
  logic [1:0] err_code_o;

  int n_checks = 0;
  int n_fail = 0;
  int dl = NEVER;
  int dh = 0;
  int lc = 0;
  int hc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_reset_seq #(
    .CLK_HZ(1000), .MIN_PULSE(MINP), .LOW_TIMEOUT(LOT), .HIGH_TIMEOUT(HIT)
  ) u_cfg_reset_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_n_i(init_n_i),
    .prog_n_o(prog_n_o), .busy_o(busy_o), .ready_o(ready_o),
    .err_o(err_o), .err_code_o(err_code_o)
  );

  // device model: low after dl edges of low request, high dh edges after release
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      init_n_i = 1'b1; lc = 0; hc = 0;
    end else if (!prog_n_o) begin
      hc = 0;
      if (init_n_i) begin
        if (lc == dl) init_n_i = 1'b0;
        else lc++;
      end
    end else begin
      lc = 0;
      if (!init_n_i) begin
        if (hc == dh) init_n_i = 1'b1;
        else hc++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int d_low, input int d_high, input int inject_k);
    int low_w = 0;
    int rdy_k = -1;
    int rdy_n = 0;
    int err_k = -1;
    int code = 0;
    int busy0 = 0;
    int err0 = 0;
    int exp_r, exp_w, exp_rdy, exp_err, exp_code;
    bit low_ok, high_ok;
    dl = d_low;
    dh = d_high;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy0 = busy_o;
    err0 = err_o;
    for (int k = 0; k < 60; k++) begin
      if (k == inject_k) start_i = 1'b1;
      else start_i = 1'b0;
      if (!prog_n_o) low_w++;
      if (ready_o) begin
        rdy_n++;
        if (rdy_k < 0) rdy_k = k;
      end
      if (err_o && err_k < 0) begin
        err_k = k;
        code = int'(err_code_o);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    low_ok  = (d_low <= LOT - 3);
    high_ok = (d_high <= HIT - 2);
    exp_r = (MINP + 1 > d_low + 3) ? MINP + 1 : d_low + 3;
    if (!low_ok) begin
      exp_w = LOT; exp_rdy = -1; exp_err = LOT; exp_code = 1;
    end else if (high_ok) begin
      exp_w = exp_r; exp_rdy = exp_r + d_high + 3; exp_err = -1; exp_code = 0;
    end else begin
      exp_w = exp_r; exp_rdy = -1; exp_err = exp_r + 1 + HIT; exp_code = 2;
    end
    check(busy0 == 1, "R8 busy after start", busy0, 1);
    check(err0 == 0, "R9 error cleared by start", err0, 0);
    check(low_w >= MINP, "R3 minimum low width", low_w, MINP);
    if (low_ok)
      check(low_w == exp_w, "R4 release edge after synced low", low_w, exp_w);
    else
      check(low_w == exp_w, "R5 release at low timeout", low_w, exp_w);
    if (exp_rdy >= 0) begin
      check(rdy_k == exp_rdy, "R6 ready edge", rdy_k, exp_rdy);
      check(rdy_n == 1, "R6 single ready pulse", rdy_n, 1);
      check(err_k == -1, "R6 no error on success", err_k, -1);
      check(busy_o == 0, "R8 busy low when ready", busy_o, 0);
    end else begin
      check(rdy_n == 0, "R5 no ready on failure", rdy_n, 0);
      if (exp_code == 1) begin
        check(err_k == exp_err, "R5 low timeout edge", err_k, exp_err);
        check(code == 1, "R5 code 01", code, 1);
      end else begin
        check(err_k == exp_err, "R7 high timeout edge", err_k, exp_err);
        check(code == 2, "R7 code 10", code, 2);
      end
      check(err_o == 1, "R9 error sticky", err_o, 1);
      check(busy_o == 0, "R8 busy low on error", busy_o, 0);
    end
    dl = NEVER;
    dh = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prog_n_o == 1, "R1 prog released", prog_n_o, 1);
    check(busy_o == 0, "R1 busy low", busy_o, 0);
    check(ready_o == 0, "R1 ready low", ready_o, 0);
    check(err_o == 0, "R1 error low", err_o, 0);
    check(err_code_o == 2'b00, "R1 code 00", int'(err_code_o), 0);
    for (int a = 0; a <= LOT + 1; a++) begin
      if (a <= LOT - 3) begin
        for (int b = 0; b <= HIT + 1; b++) run(a, b, -1);
      end else begin
        run(a, 0, -1);
      end
    end
    run(NEVER, 0, -1);
    // R2: start while busy is ignored; timing must match the undisturbed run
    run(2, 3, 5);
    run(1, 2, 9);
    run(3, HIT, 8);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule